// File: doc/BRIEF.md
# Accumulator Extract With Rounding Saturation

This unit pulls a 32-bit word out of a 64-bit signed accumulator. The accumulator arrives as two 32-bit halves, high and low, together with a 5-bit right-shift amount and a 2-bit mode. The unit forms a 65-bit intermediate. When the shift amount is nonzero, that intermediate is the accumulator shifted right by one place fewer than requested. When the shift amount is zero, it is the accumulator shifted left by one. The unit can add a rounding increment at the bottom bit. The 32-bit word sits one place above that bottom bit, so the final one-bit drop is implicit.

The unit also tests whether the scaled value fits in a signed 32-bit word. If it does not, the unit sets a sticky overflow flag at bit 23 of a status register it keeps. In saturating mode it also clamps the result. Software reloads the status register through a write port, which is the only way to clear the flag. An accepted request produces its result on the following clock edge.

Top module: `acx_extract`

## Requirements
- R1: Mode 2'b00 (truncate) returns the low 32 bits of floor(acc / 2^shamt), where acc = {acc_hi, acc_lo} is read as signed. No rounding increment is applied.
- R2: Mode 2'b01 (round) adds 1 at intermediate bit 0 before extraction. For shamt > 0 the result is the low 32 bits of floor((acc + 2^(shamt-1)) / 2^shamt). For shamt = 0 the result is the low 32 bits of acc.
- R3: Overflow is raised when the extracted value lies outside [-2^31, 2^31-1]. For the truncate modes the extracted value is unrounded; for the rounding modes it is rounded. A carry out of intermediate bit 63 toggles bit 64 (modulo 2).
- R4: Mode 2'b10 (round and saturate) rounds as in R2. On overflow it returns 32'h7FFFFFFF when intermediate bit 64 is 0 (positive) and 32'h80000000 when it is 1.
- R5: Mode 2'b11 behaves exactly as truncate, including the overflow test.
- R6: An overflowing request sets status bit 23 on the edge that registers its result. Later non-overflowing requests leave the bit set.
- R7: A status write loads all 32 bits, including bit 23, from stat_wdata. If an overflowing request is accepted in the same cycle as the write, bit 23 ends set. Requests never change any status bit other than 23.
- R8: out_valid rises one cycle after in_valid, and out_word carries that request's result. While in_valid is low, out_word holds its value. Reset clears out_valid, out_word and stat_q.
- R9: The following fixed vectors must hold, all with shamt 31:
  - An all-ones accumulator gives 0 in round mode, 0 in saturate mode and 32'hFFFFFFFF in truncate mode, with bit 23 clear in each case.
  - Accumulator 64'h80000000_00000000 in saturate mode gives 32'h80000000 and sets bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| acc_hi | input | 32 | Accumulator upper half |
| acc_lo | input | 32 | Accumulator lower half |
| shamt | input | 5 | Right-shift amount |
| mode | input | 2 | 00 truncate, 01 round, 10 round+saturate, 11 as truncate |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 32 | Status register write data |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_word | output | 32 | Extracted word |
| stat_q | output | 32 | Status register, bit 23 is sticky overflow |

## Verification
The bench builds the block with its defaults: 32-bit halves, a 5-bit shift amount and the flag at bit 23. At that size every shift amount and every mode code, reserved code included, is swept against a fixed set of edge accumulators plus pseudo-random ones. This brings both 32-bit boundary crossings within reach for each shift, as well as the carry into bit 64 that rounding an all-ones value produces.

Before each request the status register is preloaded with a pattern that has bit 23 clear. The check on stat_q then covers flag setting and the pass-through of the other bits together. Directed steps cover stickiness, clearing by a write, and a write that coincides with an overflow.

// File: rtl/acx_pkg.sv
package acx_pkg;
   typedef enum logic [1:0] {
      MODE_TRUNC = 2'b00,
      MODE_ROUND = 2'b01,
      MODE_SAT   = 2'b10,
      MODE_RSVD  = 2'b11
   } acx_mode_e;
endpackage

// File: rtl/acx_shift.sv
// Forms the 65-bit intermediate: the accumulator scaled by 2^(1-shamt).
module acx_shift #(
   parameter int HALF_W  = 32,
   parameter int SHIFT_W = 5,
   localparam int ACC_W  = 2 * HALF_W
) (
   input  logic [ACC_W-1:0]   acc,
   input  logic [SHIFT_W-1:0] sh,
   output logic [ACC_W-1:0]   mid_lo,
   output logic               mid_top
);
   logic [SHIFT_W-1:0] sh_m1;

   always_comb begin
      sh_m1 = sh - {{(SHIFT_W-1){1'b0}}, 1'b1};
      if (sh == '0) begin
         mid_lo = {acc[ACC_W-2:0], 1'b0};
      end else begin
         mid_lo = ACC_W'($signed(acc) >>> sh_m1);
      end
      mid_top = acc[ACC_W-1];
   end
endmodule

// File: rtl/acx_round.sv
// Optional rounding increment, range test on {bit64, bits 63:HALF_W}, clamp.
module acx_round #(
   parameter int HALF_W = 32,
   localparam int ACC_W = 2 * HALF_W,
   localparam int UP_W  = ACC_W - HALF_W
) (
   input  logic [ACC_W-1:0]  mid_lo,
   input  logic              mid_top,
   input  logic              rnd_en,
   input  logic              sat_en,
   output logic [HALF_W-1:0] word,
   output logic              ovf
);
   logic [ACC_W:0]  sum;
   logic            top;
   logic [UP_W-1:0] upper;
   logic            all_zero;
   logic            all_one;

   always_comb begin
      sum      = {1'b0, mid_lo} + {{ACC_W{1'b0}}, rnd_en};
      top      = mid_top ^ sum[ACC_W];
      upper    = sum[ACC_W-1:HALF_W];
      all_zero = !top && (upper == '0);
      all_one  = top && (&upper);
      ovf      = !(all_zero || all_one);
      if (ovf && sat_en) begin
         word = top ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};
      end else begin
         word = sum[HALF_W:1];
      end
   end
endmodule

// File: rtl/acx_status.sv
// Status register with a sticky overflow flag at FLAG_POS.
module acx_status #(
   parameter int STAT_W   = 32,
   parameter int FLAG_POS = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [STAT_W-1:0] wdata,
   input  logic              set_flag,
   output logic [STAT_W-1:0] q
);
   localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(1) << FLAG_POS;

   logic [STAT_W-1:0] q_nxt;

   always_comb begin
      q_nxt = we ? wdata : q;
      if (set_flag) q_nxt = q_nxt | FLAG_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && q[FLAG_POS]) |=> q[FLAG_POS]);

   // R7
   other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ((q & ~FLAG_MASK) == ($past(q) & ~FLAG_MASK)));

   // R7
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !set_flag) |=> (q == $past(wdata)));
endmodule

// File: rtl/acx_extract.sv
module acx_extract #(
   parameter int HALF_W   = 32,
   parameter int SHIFT_W  = 5,
   parameter int STAT_W   = 32,
   parameter int FLAG_POS = 23
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [HALF_W-1:0]  acc_hi,
   input  logic [HALF_W-1:0]  acc_lo,
   input  logic [SHIFT_W-1:0] shamt,
   input  logic [1:0]         mode,
   input  logic               stat_we,
   input  logic [STAT_W-1:0]  stat_wdata,
   output logic               out_valid,
   output logic [HALF_W-1:0]  out_word,
   output logic [STAT_W-1:0]  stat_q
);
   import acx_pkg::*;

   localparam int ACC_W = 2 * HALF_W;

   if ((1 << SHIFT_W) > ACC_W) begin : g_bad_shift
      $error("SHIFT_W reaches past the accumulator");
   end
   if (FLAG_POS >= STAT_W) begin : g_bad_flag
      $error("FLAG_POS outside the status register");
   end
   if (HALF_W < 2) begin : g_bad_half
      $error("HALF_W too small");
   end

   acx_mode_e         mode_e;
   logic              rnd_en;
   logic              sat_en;
   logic [ACC_W-1:0]  mid_lo;
   logic              mid_top;
   logic [HALF_W-1:0] word;
   logic              ovf;

   always_comb begin
      mode_e = acx_mode_e'(mode);
      rnd_en = (mode_e == MODE_ROUND) || (mode_e == MODE_SAT);
      sat_en = (mode_e == MODE_SAT);
   end

   acx_shift #(.HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_shift (
      .acc     ({acc_hi, acc_lo}),
      .sh      (shamt),
      .mid_lo  (mid_lo),
      .mid_top (mid_top)
   );

   acx_round #(.HALF_W(HALF_W)) u_round (
      .mid_lo  (mid_lo),
      .mid_top (mid_top),
      .rnd_en  (rnd_en),
      .sat_en  (sat_en),
      .word    (word),
      .ovf     (ovf)
   );

   acx_status #(.STAT_W(STAT_W), .FLAG_POS(FLAG_POS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (stat_we),
      .wdata    (stat_wdata),
      .set_flag (in_valid && ovf),
      .q        (stat_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_word <= word;
      end
   end

   // R8
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_word)));

   // R4
   sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && ovf) |=>
         (out_word == {1'b1, {(HALF_W-1){1'b0}}} ||
          out_word == {1'b0, {(HALF_W-1){1'b1}}}));

   // R6
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ovf) |=> stat_q[FLAG_POS]);

   // R3
   no_ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ovf) |=> (out_word[HALF_W-1] == $past(mid_top ^ (rnd_en && (&mid_lo)))));
endmodule

// File: tb/test_acx_extract.sv
module test_acx_extract;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] FLAG = 32'h0080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] acc_hi = '0;
   logic [31:0] acc_lo = '0;
   logic [4:0]  shamt = '0;
   logic [1:0]  mode = '0;
   logic        stat_we = 1'b0;
   logic [31:0] stat_wdata = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic [31:0] stat_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acx_extract i_acx_extract (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .acc_hi(acc_hi), .acc_lo(acc_lo), .shamt(shamt), .mode(mode),
      .stat_we(stat_we), .stat_wdata(stat_wdata),
      .out_valid(out_valid), .out_word(out_word), .stat_q(stat_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Arithmetic model: floor(2*acc / 2^s) (+1 when rounding), then halve.
   task automatic model(input logic [63:0] acc, input int s, input int m,
                        output logic [31:0] r, output bit ov);
      logic signed [65:0] w;
      logic signed [65:0] q;
      w = $signed({acc[63], acc[63], acc}) * 2;
      w = w >>> s;
      if (m == 1 || m == 2) w = w + 66'sd1;
      q = w >>> 1;
      ov = (q > 66'sd2147483647) || (q < -66'sd2147483648);
      if (ov && m == 2) r = (q < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else              r = q[31:0];
   endtask

   task automatic wr_stat(input logic [31:0] v);
      @(negedge clk);
      stat_we = 1'b1; stat_wdata = v;
      @(negedge clk);
      stat_we = 1'b0;
   endtask

   task automatic apply(input logic [63:0] acc, input int s, input int m);
      @(negedge clk);
      acc_hi = acc[63:32]; acc_lo = acc[31:0];
      shamt = 5'(s); mode = 2'(m); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_vec(input logic [63:0] acc, input int s, input int m, input logic [31:0] pre);
      logic [31:0] er;
      bit eo;
      string tag;
      model(acc, s, m, er, eo);
      case (m)
         0: tag = "R1";
         1: tag = "R2";
         2: tag = "R4";
         default: tag = "R5";
      endcase
      wr_stat(pre);
      apply(acc, s, m);
      chk(tag, out_word, er);
      chk("R3/R6/R7", stat_q, pre | (eo ? FLAG : 32'h0));
   endtask

   logic [63:0] pats [0:9];

   initial begin
      logic [63:0] lfsr;
      logic [31:0] hold;
      pats[0] = 64'h0;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h8000_0000_0000_0000;
      pats[3] = 64'h7FFF_FFFF_FFFF_FFFF;
      pats[4] = 64'h0000_0000_0000_0001;
      pats[5] = 64'h0000_0000_7FFF_FFFF;
      pats[6] = 64'h0000_0000_8000_0000;
      pats[7] = 64'hFFFF_FFFF_8000_0000;
      pats[8] = 64'h0000_0001_0000_0000;
      pats[9] = 64'hFFFF_FFFF_7FFF_FFFF;

      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 reset valid", {31'h0, out_valid}, 32'h0);
      chk("R8 reset word", out_word, 32'h0);
      chk("R8 reset status", stat_q, 32'h0);
      rst_n = 1'b1;

      // R9: fixed vectors
      wr_stat(32'h0); apply(64'hFFFF_FFFF_FFFF_FFFF, 31, 1);
      chk("R9 round ones", out_word, 32'h0);
      chk("R9 round ones flag", stat_q & FLAG, 32'h0);
      wr_stat(32'h0); apply(64'h8000_0000_0000_0000, 31, 2);
      chk("R9 sat min", out_word, 32'h8000_0000);
      chk("R9 sat min flag", stat_q & FLAG, FLAG);
      wr_stat(32'h0); apply(64'hFFFF_FFFF_FFFF_FFFF, 31, 2);
      chk("R9 sat ones", out_word, 32'h0);
      chk("R9 sat ones flag", stat_q & FLAG, 32'h0);
      wr_stat(32'h0); apply(64'hFFFF_FFFF_FFFF_FFFF, 31, 0);
      chk("R9 trunc ones", out_word, 32'hFFFF_FFFF);
      chk("R9 trunc ones flag", stat_q & FLAG, 32'h0);

      // R6: stickiness across a non-overflowing request
      wr_stat(32'h0); apply(64'h7FFF_FFFF_FFFF_FFFF, 0, 0);
      apply(64'h0, 5, 1);
      chk("R6 sticky", stat_q & FLAG, FLAG);
      // R7: write clears the flag
      wr_stat(32'h1234_5678 & ~FLAG);
      chk("R7 write clear", stat_q, 32'h1234_5678 & ~FLAG);
      // R7: write concurrent with overflow
      @(negedge clk);
      stat_we = 1'b1; stat_wdata = 32'h0000_00FF;
      acc_hi = 32'h7FFF_FFFF; acc_lo = '0; shamt = 5'd0; mode = 2'd0; in_valid = 1'b1;
      @(negedge clk);
      stat_we = 1'b0; in_valid = 1'b0;
      chk("R7 concurrent", stat_q, 32'h0000_00FF | FLAG);
      // R8: hold while idle
      hold = out_word;
      acc_hi = 32'h1; acc_lo = 32'h2; shamt = 5'd3;
      @(negedge clk);
      chk("R8 hold", out_word, hold);
      chk("R8 idle valid", {31'h0, out_valid}, 32'h0);

      // sweep: patterns and pseudo-random accumulators, every shift and mode
      lfsr = 64'hACE1_2468_1357_9BDF;
      for (int p = 0; p < 18; p++) begin
         logic [63:0] a;
         if (p < 10) a = pats[p];
         else begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            a = (p[0]) ? lfsr : {{24{lfsr[40]}}, lfsr[39:0]};
         end
         for (int s = 0; s < 32; s++) begin
            for (int m = 0; m < 4; m++) begin
               run_vec(a, s, m, (32'h5A5A_5A5A ^ 32'(s * 7 + m)) & ~FLAG);
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule